// File: doc/BRIEF.md
# Flash Controller Command and Interrupt Registers

This block is the register front end of a NAND-style flash controller, reached over a 16-bit register bus with a combinational read path and a single-cycle write strobe. It holds the command register, two configuration registers, a read-only controller status register, an interrupt status register and a start-buffer register. It drives an interrupt line whose polarity software selects, and a ready line that software sets directly.

A command written while nothing is pending and no operation is outstanding is classified. Executor commands are handed to an external executor with a one-cycle start strobe. The two reset codes perform a warm reset in place. Any other code is flagged as an error at once. The executor later reports a completion: a two-bit kind and an error flag. From these the block sets the interrupt and status bits. Software acknowledges a completion by clearing the master interrupt bit, and that also wipes the sticky error flags.

Top module: `flash_cmd_regs`

## Requirements
- R1: A cold reset (rst_n low) leaves interrupt status 0x8080. A warm reset (accepted command 0x00F0 or 0x00F3) leaves it 0x8010. Both kinds leave configuration 1 at 0x40C0, configuration 2 at 0, status at 0, command at 0, buffer address 0, sector count 1, rdy high and no operation outstanding. A warm reset raises no start strobe.
- R2: irq equals interrupt-status bit 15 XOR the inverse of configuration-1 bit 6. The line is active high with bit 6 set and active low with it clear.
- R3: A write to the interrupt register (offset 4) ANDs the written value into it. If bit 15 is 0 after the write, status bits 10 to 13 are all cleared; otherwise they are kept.
- R4: A command write (offset 0) is ignored, with no strobe and no change to the command register, while interrupt bit 15 is 1 or an executor command is outstanding.
- R5: A completion (done_valid high while a command is outstanding) sets interrupt bit 15 plus a type bit chosen by done_kind: 0 erase sets bit 5, 1 program sets bit 6, 2 load sets bit 7, 3 other sets no type bit. With done_err high it also sets status bit 10, plus bit 11 for erase, bit 12 for program or bit 13 for load.
- R6: The executor codes are 0x00, 0x13, 0x80, 0x1A, 0x1B, 0x23, 0x27, 0x2A, 0x2C, 0x30, 0x65, 0x71, 0x94, 0x95 and 0xB0. An accepted code that is neither one of these nor a reset code sets status bit 10 and interrupt bit 15, with no strobe.
- R7: A write to the start-buffer register (offset 5) takes bits [11:8] as the buffer address and bits [1:0] as the sector count, where 0 means 4. A read returns the address in [11:8] and the written count field in [1:0].
- R8: cmd_start is high for exactly the one cycle after an accepted executor command write, with cmd_code holding that code. Only one command is outstanding at a time.
- R9: A read of configuration 1 (offset 1) returns the stored value with bits [4:0] as 0. A write to it sets rdy to bit 7 of the written value.
- R10: Configuration 2 (offset 2) reads back what was written. Status (offset 3) is read-only. Any offset from 6 upward reads 0, and a write there changes nothing.
- R11: done_valid while no command is outstanding has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low cold reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| done_valid | input | 1 | Executor completion pulse |
| done_kind | input | 2 | Completion kind: 0 erase, 1 program, 2 load, 3 other |
| done_err | input | 1 | Completion failed |
| cmd_start | output | 1 | One-cycle start strobe to the executor |
| cmd_code | output | 16 | Last accepted command code |
| buf_addr | output | 4 | Buffer address from the start-buffer register |
| sec_count | output | 3 | Sector count, 1 to 4 |
| irq | output | 1 | Interrupt line, polarity from configuration 1 |
| rdy | output | 1 | Ready line |

## Verification
The bound checker watches several rules on every cycle. The start strobe must last one cycle and must only appear while a command is outstanding. A command write made while the master bit is pending must raise no strobe. Every completion must set the master bit and drive irq to its asserted level. An acknowledging write must wipe the error flags. rdy must follow configuration writes. The exact register images can only be shown by the bench's scenarios and its clock-by-clock reference model: the reset values, the AND-merge of partial acknowledgements, the refusal while busy, the unknown-code path, the start-buffer decoding and the warm reset restoring changed registers.

// File: rtl/flash_cmd_regs.sv
module flash_cmd_regs #(
  parameter int          AW       = 4,
  parameter logic [15:0] CFG1_RST = 16'h40C0,
  parameter logic [15:0] INT_COLD = 16'h8080,
  parameter logic [15:0] INT_WARM = 16'h8010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [15:0]   reg_wdata,
  output logic [15:0]   reg_rdata,
  input  logic          done_valid,
  input  logic [1:0]    done_kind,
  input  logic          done_err,
  output logic          cmd_start,
  output logic [15:0]   cmd_code,
  output logic [3:0]    buf_addr,
  output logic [2:0]    sec_count,
  output logic          irq,
  output logic          rdy
);
  localparam logic [AW-1:0] A_CMD  = AW'(0);
  localparam logic [AW-1:0] A_CFG1 = AW'(1);
  localparam logic [AW-1:0] A_CFG2 = AW'(2);
  localparam logic [AW-1:0] A_STAT = AW'(3);
  localparam logic [AW-1:0] A_INT  = AW'(4);
  localparam logic [AW-1:0] A_BUF  = AW'(5);

  logic [15:0] int_q, int_n, cfg2_q, cmd_q;
  logic [15:5] cfg1_q;
  logic [3:0]  err_q, err_n, buf_q;
  logic [1:0]  cnt_q;
  logic        busy_q, start_q, rdy_q;
  logic        wr_cmd, accept, is_rst, is_exec, is_bad, done_ok, known;

  assign known   = reg_wdata inside {16'h0000, 16'h0013, 16'h0080, 16'h001A, 16'h001B,
                                     16'h0023, 16'h0027, 16'h002A, 16'h002C, 16'h0030,
                                     16'h0065, 16'h0071, 16'h0094, 16'h0095, 16'h00B0};
  assign wr_cmd  = reg_we && reg_addr == A_CMD;
  assign accept  = wr_cmd && !int_q[15] && !busy_q;
  assign is_rst  = accept && (reg_wdata == 16'h00F0 || reg_wdata == 16'h00F3);
  assign is_exec = accept && known;
  assign is_bad  = accept && !known && !is_rst;
  assign done_ok = done_valid && busy_q;

  always_comb begin
    int_n = int_q;
    err_n = err_q;
    if (reg_we && reg_addr == A_INT) begin
      int_n = int_q & reg_wdata;
      if (!int_n[15]) err_n = 4'b0;
    end
    if (is_bad) begin
      int_n[15] = 1'b1;
      err_n[0]  = 1'b1;
    end
    if (done_ok) begin
      int_n[15] = 1'b1;
      case (done_kind)
        2'd0:    int_n[5] = 1'b1;
        2'd1:    int_n[6] = 1'b1;
        2'd2:    int_n[7] = 1'b1;
        default: ;
      endcase
      if (done_err) begin
        err_n[0] = 1'b1;
        case (done_kind)
          2'd0:    err_n[1] = 1'b1;
          2'd1:    err_n[2] = 1'b1;
          2'd2:    err_n[3] = 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q   <= INT_COLD;
      cfg1_q  <= CFG1_RST[15:5];
      cfg2_q  <= '0;
      err_q   <= '0;
      cmd_q   <= '0;
      buf_q   <= '0;
      cnt_q   <= 2'd1;
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      rdy_q   <= 1'b1;
    end else begin
      start_q <= is_exec;
      if (is_rst) begin
        int_q  <= INT_WARM;
        cfg1_q <= CFG1_RST[15:5];
        cfg2_q <= '0;
        err_q  <= '0;
        cmd_q  <= '0;
        buf_q  <= '0;
        cnt_q  <= 2'd1;
        busy_q <= 1'b0;
        rdy_q  <= 1'b1;
      end else begin
        int_q <= int_n;
        err_q <= err_n;
        if (accept) cmd_q <= reg_wdata;
        if (is_exec) busy_q <= 1'b1;
        else if (done_ok) busy_q <= 1'b0;
        if (reg_we && reg_addr == A_CFG1) begin
          cfg1_q <= reg_wdata[15:5];
          rdy_q  <= reg_wdata[7];
        end
        if (reg_we && reg_addr == A_CFG2) cfg2_q <= reg_wdata;
        if (reg_we && reg_addr == A_BUF) begin
          buf_q <= reg_wdata[11:8];
          cnt_q <= reg_wdata[1:0];
        end
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_CMD:   reg_rdata = cmd_q;
      A_CFG1:  reg_rdata = {cfg1_q, 5'b0};
      A_CFG2:  reg_rdata = cfg2_q;
      A_STAT:  reg_rdata = {2'b0, err_q[3], err_q[2], err_q[1], err_q[0], 10'b0};
      A_INT:   reg_rdata = int_q;
      A_BUF:   reg_rdata = {4'b0, buf_q, 6'b0, cnt_q};
      default: reg_rdata = 16'h0000;
    endcase
  end

  assign cmd_start = start_q;
  assign cmd_code  = cmd_q;
  assign buf_addr  = buf_q;
  assign sec_count = (cnt_q == 2'd0) ? 3'd4 : {1'b0, cnt_q};
  assign irq       = int_q[15] ^ ~cfg1_q[6];
  assign rdy       = rdy_q;
endmodule

// File: rtl/flash_cmd_regs_chk.sv
module flash_cmd_regs_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic [15:0]   reg_wdata,
  input logic          done_valid,
  input logic          cmd_start,
  input logic          irq,
  input logic          rdy,
  input logic [15:0]   int_q,
  input logic [15:5]   cfg1_q,
  input logic [3:0]    err_q,
  input logic          busy_q
);
  p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> !cmd_start);

  p_strobe_outstanding_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> busy_q);

  p_refuse_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == AW'(0) && int_q[15]) |=> !cmd_start);

  p_master_on_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && busy_q) |=> int_q[15]);

  p_irq_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && busy_q && !(reg_we && reg_addr == AW'(1))) |=> irq == cfg1_q[6]);

  p_err_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == AW'(4) && !reg_wdata[15] && !done_valid) |=> err_q == 4'b0);

  p_rdy_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == AW'(1)) |=> rdy == $past(reg_wdata[7]));
endmodule

bind flash_cmd_regs flash_cmd_regs_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_flash_cmd_regs.sv
`timescale 1ns/1ps
module sim_flash_cmd_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        done_valid = 1'b0;
  logic [1:0]  done_kind = '0;
  logic        done_err = 1'b0;
  logic        cmd_start, irq, rdy;
  logic [15:0] cmd_code;
  logic [3:0]  buf_addr;
  logic [2:0]  sec_count;

  int checks = 0;
  int errors = 0;
  bit compare_on = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  flash_cmd_regs u0 (.*);

  // behavioural reference
  logic [15:0] m_int, m_cfg1, m_cfg2, m_stat, m_cmd;
  logic [3:0]  m_buf;
  int          m_cnt;
  bit          m_busy, m_start, m_rdy, b0, st;

  task automatic m_reset(input bit cold);
    m_int = cold ? 16'h8080 : 16'h8010;
    m_cfg1 = 16'h40C0; m_cfg2 = 0; m_stat = 0; m_cmd = 0;
    m_buf = 0; m_cnt = 1; m_busy = 0; m_rdy = 1;
  endtask

  function automatic bit is_exec_code(input logic [15:0] c);
    return c inside {16'h00, 16'h13, 16'h80, 16'h1A, 16'h1B, 16'h23, 16'h27, 16'h2A,
                     16'h2C, 16'h30, 16'h65, 16'h71, 16'h94, 16'h95, 16'hB0};
  endfunction

  initial begin m_reset(1); m_start = 0; end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_reset(1); m_start = 0;
    end else begin
      b0 = m_busy;
      st = 0;
      if (reg_we && reg_addr == 0) begin
        if (!m_int[15] && !m_busy) begin
          if (reg_wdata == 16'hF0 || reg_wdata == 16'hF3) m_reset(0);
          else begin
            m_cmd = reg_wdata;
            if (is_exec_code(reg_wdata)) begin m_busy = 1; st = 1; end
            else begin m_int = m_int | 16'h8000; m_stat = m_stat | 16'h0400; end
          end
        end
      end else if (reg_we) begin
        case (reg_addr)
          1: begin m_cfg1 = reg_wdata & 16'hFFE0; m_rdy = reg_wdata[7]; end
          2: m_cfg2 = reg_wdata;
          4: begin
               m_int = m_int & reg_wdata;
               if (m_int[15] == 0) m_stat = 0;
             end
          5: begin m_buf = reg_wdata[11:8]; m_cnt = reg_wdata[1:0]; end
          default: ;
        endcase
      end
      if (done_valid && b0) begin
        m_busy = 0;
        m_int = m_int | 16'h8000 | (done_kind == 0 ? 16'h20 : done_kind == 1 ? 16'h40 :
                                    done_kind == 2 ? 16'h80 : 16'h0);
        if (done_err)
          m_stat = m_stat | 16'h0400 | (done_kind == 0 ? 16'h0800 : done_kind == 1 ? 16'h1000 :
                                        done_kind == 2 ? 16'h2000 : 16'h0);
      end
      m_start = st;
    end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (compare_on) begin
    check("R2 irq", {15'b0, irq}, {15'b0, m_int[15] ^ ~m_cfg1[6]});
    check("R9 rdy", {15'b0, rdy}, {15'b0, m_rdy});
    check("R8 cmd_start", {15'b0, cmd_start}, {15'b0, m_start});
    check("R4 cmd_code", cmd_code, m_cmd);
    check("R7 buf_addr", {12'b0, buf_addr}, {12'b0, m_buf});
    check("R7 sec_count", {13'b0, sec_count}, (m_cnt == 0) ? 16'd4 : 16'(m_cnt));
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk); reg_addr = a; #1;
    check(tag, reg_rdata, exp);
  endtask

  task automatic finish_done(input logic [1:0] k, input bit e);
    @(negedge clk); done_valid = 1; done_kind = k; done_err = e;
    @(negedge clk); done_valid = 0; done_err = 0;
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    compare_on = 1;
    // R1 cold reset values
    rd(4, 16'h8080, "R1 int cold");
    rd(1, 16'h40C0, "R1 cfg1 cold");
    rd(2, 16'h0000, "R1 cfg2 cold");
    rd(3, 16'h0000, "R1 status cold");
    rd(5, 16'h0001, "R1 startbuf cold");
    check("R2 irq active high after reset", {15'b0, irq}, 16'd1);
    // R4 refused while master bit pending
    wr(0, 16'h0080);
    rd(0, 16'h0000, "R4 refused while pending");
    wr(4, 16'h0000);
    rd(4, 16'h0000, "R3 int cleared");
    // R7 start buffer
    wr(5, 16'h0A02);
    rd(5, 16'h0A02, "R7 startbuf readback");
    check("R7 count 2", {13'b0, sec_count}, 16'd2);
    wr(5, 16'h0300);
    check("R7 count zero means 4", {13'b0, sec_count}, 16'd4);
    // R8 R5 program with error
    wr(0, 16'h0080);
    rd(0, 16'h0080, "R8 command accepted");
    finish_done(1, 1);
    rd(4, 16'h8040, "R5 program completion");
    rd(3, 16'h1400, "R5 program error");
    wr(0, 16'h0000);
    rd(0, 16'h0080, "R4 refused after completion");
    // R3 partial acknowledge keeps errors
    wr(4, 16'h8000);
    rd(4, 16'h8000, "R3 and-merge");
    rd(3, 16'h1400, "R3 errors kept while bit15 set");
    wr(4, 16'h7FFF);
    rd(3, 16'h0000, "R3 errors cleared");
    // load error then erase ok
    wr(0, 16'h0000);
    finish_done(2, 1);
    rd(4, 16'h8080, "R5 load completion");
    rd(3, 16'h2400, "R5 load error");
    wr(4, 16'h0000);
    wr(0, 16'h0094);
    finish_done(0, 0);
    rd(4, 16'h8020, "R5 erase completion");
    rd(3, 16'h0000, "R5 erase ok no error");
    wr(4, 16'h0000);
    // R6 unknown code
    wr(0, 16'h0055);
    rd(3, 16'h0400, "R6 unknown sets status");
    rd(4, 16'h8000, "R6 unknown sets master");
    wr(4, 16'h0000);
    // R9 cfg1 masking, rdy, active-low irq
    wr(1, 16'h0035);
    rd(1, 16'h0020, "R9 cfg1 low bits masked");
    check("R9 rdy low", {15'b0, rdy}, 16'd0);
    check("R2 active low idle", {15'b0, irq}, 16'd1);
    wr(0, 16'h0023);
    // R4 busy refusal
    wr(0, 16'h0027);
    rd(0, 16'h0023, "R4 refused while outstanding");
    finish_done(3, 1);
    rd(4, 16'h8000, "R5 other completion");
    rd(3, 16'h0400, "R5 other error");
    check("R2 active low asserted", {15'b0, irq}, 16'd0);
    wr(4, 16'h0000);
    // R11 stray completion
    finish_done(2, 1);
    rd(4, 16'h0000, "R11 stray completion int");
    rd(3, 16'h0000, "R11 stray completion status");
    // R10 cfg2 and unmapped
    wr(2, 16'h1234);
    rd(2, 16'h1234, "R10 cfg2 readback");
    wr(3, 16'hFFFF);
    rd(3, 16'h0000, "R10 status read-only");
    wr(9, 16'hFFFF);
    rd(9, 16'h0000, "R10 unmapped read");
    rd(4, 16'h0000, "R10 unmapped write no effect");
    // R1 warm reset
    wr(5, 16'h0501);
    wr(0, 16'h00F0);
    rd(4, 16'h8010, "R1 int warm");
    rd(1, 16'h40C0, "R1 cfg1 warm");
    rd(2, 16'h0000, "R1 cfg2 warm");
    rd(0, 16'h0000, "R1 cmd warm");
    rd(5, 16'h0001, "R1 startbuf warm");
    check("R1 rdy warm", {15'b0, rdy}, 16'd1);
    repeat (3) @(negedge clk);
    finished = 1;
    report();
  end
endmodule